// File: doc/BRIEF.md
# Multi-Register Store Sequencer

This block carries out stores that span several general-purpose registers. A single start pulse hands it a command. The block then walks a run of registers through a combinational register-file read port and issues one memory write per accepted cycle on a write port with byte strobes. It raises a one-cycle completion flag when the run ends.

The block has three kinds of operation. A word-multiple store writes full words, beginning at a given register and ending at register 31. An immediate-count string store writes a byte count taken from a 5-bit field, where 0 stands for 32. An indexed-count string store takes its byte count from a 7-bit transfer-count field and adds an index value to its base. String stores write one byte per cycle. Each register gives up its bytes most significant first, and the register number wraps from 31 back to 0.

The base operand can be selected as the literal value zero. This lets the caller form absolute addresses. All command fields are captured at the start pulse, so the caller may change them while the run is in progress.

Top module: `mss_store_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `mem_we` are all low.
- R2: For `mode` 2'b00 (word multiple), the block writes registers `src_reg` through 31 in ascending order, one word per write. The first address is base plus the sign-extended 16-bit `disp`, and each later address is 4 higher. `mem_wdata` equals the register value and `mem_be` is 4'b1111.
- R3: For `mode` 2'b01 (immediate string), the start address is the base. The byte count is `imm_count`, or 32 when `imm_count` is 0.
- R4: For `mode` 2'b10 or 2'b11 (indexed string), the start address is base plus `index_val`, and the byte count is `xfer_count` (0 to 127).
- R5: A string store issues one write per byte, and the address rises by 1 per byte. Byte lane L = address[1:0] maps to `mem_wdata` bits [31-8L:24-8L] and to `mem_be` bit 3-L. The byte sits in that lane, the other lanes are zero, and exactly one strobe is set.
- R6: String bytes come from consecutive registers beginning at `src_reg`, taken most significant byte first and four per register. Register 0 follows register 31, and the last register supplies only the n mod 4 remaining bytes when that value is nonzero.
- R7: While `mem_we` is high and `mem_ready` is low, the write in progress (address, data, strobes, read address) holds unchanged into the next cycle.
- R8: `done` is high for exactly one cycle, the cycle after the final write is accepted. `busy` is high from the cycle after start through the `done` cycle. An indexed string with count 0 makes no write and raises `done` in the cycle right after start.
- R9: A `start` pulse while `busy` is high is ignored. The run in progress goes on unchanged, and no further run follows.
- R10: When `base_is_r0` is high, the base is zero whatever `base_val` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command pulse, taken only while idle |
| mode | input | 2 | 00 word multiple, 01 immediate string, 1x indexed string |
| src_reg | input | 5 | First register of the run |
| base_is_r0 | input | 1 | Use literal zero as the base |
| base_val | input | 32 | Base register value |
| disp | input | 16 | Signed displacement for word multiple |
| index_val | input | 32 | Index register value for indexed string |
| imm_count | input | 5 | Immediate byte count, 0 meaning 32 |
| xfer_count | input | 7 | Byte count for indexed string |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 32 | Register-file read data, same cycle |
| mem_we | output | 1 | Write request |
| mem_addr | output | 32 | Byte address of the write |
| mem_wdata | output | 32 | Write data, big-endian lanes |
| mem_be | output | 4 | Byte strobes, bit 3 is lane 0 |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `rf_rdata` answers `rf_raddr` in the same cycle. They also assume the memory side may hold `mem_ready` low for any length of time, and that `start` may arrive at any point, including in the middle of a run. The bench keeps within these assumptions. It models the register file as a combinational array indexed by the read address, draws `mem_ready` at random at several duty levels, and drives a stray start pulse during a long run. It scrambles the command fields after each start to show that the command was captured.

// File: rtl/mss_pkg.sv
package mss_pkg;
    localparam int XLEN    = 32;
    localparam int NREG    = 32;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int LANES   = XLEN / 8;
    localparam int LANE_W  = $clog2(LANES);
    localparam int DISP_W  = 16;
    localparam int IMM_W   = 5;
    localparam int CNT_W   = 7;

    typedef enum logic [1:0] {K_MULT, K_STRI, K_STRX} op_kind_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [XLEN-1:0]     addr;
        logic [CNT_W-1:0]    count;
        logic [RIDX_W-1:0]   first_reg;
    } op_plan_t;

    function automatic op_kind_e kind_of(input logic [1:0] m);
        if (m[1])      return K_STRX;
        else if (m[0]) return K_STRI;
        else           return K_MULT;
    endfunction

    function automatic logic [CNT_W-1:0] imm_bytes(input logic [IMM_W-1:0] f);
        return (f == '0) ? CNT_W'(NREG) : CNT_W'(f);
    endfunction
endpackage

// File: rtl/mss_cmd_decode.sv
module mss_cmd_decode
    import mss_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [RIDX_W-1:0] src_reg,
    input  logic              base_is_r0,
    input  logic [XLEN-1:0]   base_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   index_val,
    input  logic [IMM_W-1:0]  imm_count,
    input  logic [CNT_W-1:0]  xfer_count,
    output op_plan_t          plan
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] disp_ext;

    assign base     = base_is_r0 ? '0 : base_val;
    assign disp_ext = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};

    always_comb begin
        plan.kind      = kind_of(mode);
        plan.first_reg = src_reg;
        unique case (plan.kind)
            K_MULT: begin
                plan.addr  = base + disp_ext;
                plan.count = CNT_W'(NREG) - CNT_W'(src_reg);
            end
            K_STRI: begin
                plan.addr  = base;
                plan.count = imm_bytes(imm_count);
            end
            default: begin
                plan.addr  = base + index_val;
                plan.count = xfer_count;
            end
        endcase
    end
endmodule

// File: rtl/mss_ctrl.sv
module mss_ctrl
    import mss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_plan_t          plan,
    input  logic              mem_ready,
    output op_kind_e          kind,
    output logic [XLEN-1:0]   addr,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [LANE_W-1:0] byte_sel,
    output logic              mem_we,
    output logic              busy,
    output logic              done
);
    seq_state_e        state_q;
    op_kind_e          kind_q;
    logic [XLEN-1:0]   addr_q;
    logic [RIDX_W-1:0] reg_q;
    logic [LANE_W-1:0] sel_q;
    logic [CNT_W-1:0]  remain_q;
    logic              accept;

    assign accept = (state_q == ST_RUN) && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            kind_q   <= K_MULT;
            addr_q   <= '0;
            reg_q    <= '0;
            sel_q    <= '0;
            remain_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    kind_q   <= plan.kind;
                    addr_q   <= plan.addr;
                    reg_q    <= plan.first_reg;
                    sel_q    <= '0;
                    remain_q <= plan.count;
                    state_q  <= (plan.count == '0) ? ST_DONE : ST_RUN;
                end
                ST_RUN: if (accept) begin
                    remain_q <= remain_q - CNT_W'(1);
                    if (kind_q == K_MULT) begin
                        addr_q <= addr_q + XLEN'(LANES);
                        reg_q  <= reg_q + RIDX_W'(1);
                    end else begin
                        addr_q <= addr_q + XLEN'(1);
                        sel_q  <= sel_q + LANE_W'(1);
                        if (sel_q == LANE_W'(LANES-1))
                            reg_q <= reg_q + RIDX_W'(1);
                    end
                    if (remain_q == CNT_W'(1))
                        state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign kind     = kind_q;
    assign addr     = addr_q;
    assign reg_idx  = reg_q;
    assign byte_sel = sel_q;
    assign mem_we   = (state_q == ST_RUN);
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);

    // R8: completion pulse lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: a refused write is presented again unchanged
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_ready) |=> (mem_we && $stable(addr) && $stable(reg_idx) && $stable(byte_sel)));

    // R2: word writes advance by a full word
    a_r2_word_step: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_ready && kind == K_MULT && !$past(done)) |=> (!mem_we || addr == $past(addr) + XLEN'(LANES)));

    // R6: register number stays put until its last byte lane is used
    a_r6_reg_held_mid_word: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_ready && kind != K_MULT && byte_sel != LANE_W'(LANES-1)) |=> (reg_idx == $past(reg_idx)));

    // R9: a start while busy does not restart the counters
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !mem_we) |=> !busy);
endmodule

// File: rtl/mss_lane_fmt.sv
module mss_lane_fmt
    import mss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  op_kind_e          kind,
    input  logic [LANE_W-1:0] lane,
    input  logic [LANE_W-1:0] byte_sel,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic [XLEN-1:0]   wdata,
    output logic [LANES-1:0]  be
);
    logic [7:0] pick;

    assign pick = rf_rdata[(XLEN-1) - 8*byte_sel -: 8];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = (lane == LANE_W'(g));
        assign be[LANES-1-g] = (kind == K_MULT) ? 1'b1 : hit;
        assign wdata[(XLEN-1) - 8*g -: 8] = (kind == K_MULT) ? rf_rdata[(XLEN-1) - 8*g -: 8]
                                          : (hit ? pick : 8'h00);
    end

    // R5: string writes enable exactly one lane
    a_r5_one_lane: assert property (@(posedge clk) disable iff (rst)
        (we && kind != K_MULT) |-> ($countones(be) == 1));

    // R2: word writes enable every lane
    a_r2_all_lanes: assert property (@(posedge clk) disable iff (rst)
        (we && kind == K_MULT) |-> (be == '1));
endmodule

// File: rtl/mss_store_seq.sv
module mss_store_seq
    import mss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [4:0]        src_reg,
    input  logic              base_is_r0,
    input  logic [31:0]       base_val,
    input  logic [15:0]       disp,
    input  logic [31:0]       index_val,
    input  logic [4:0]        imm_count,
    input  logic [6:0]        xfer_count,
    output logic [4:0]        rf_raddr,
    input  logic [31:0]       rf_rdata,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done
);
    op_plan_t          plan;
    op_kind_e          kind;
    logic [LANE_W-1:0] byte_sel;

    mss_cmd_decode u_dec (
        .mode       (mode),
        .src_reg    (src_reg),
        .base_is_r0 (base_is_r0),
        .base_val   (base_val),
        .disp       (disp),
        .index_val  (index_val),
        .imm_count  (imm_count),
        .xfer_count (xfer_count),
        .plan       (plan)
    );

    mss_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .plan      (plan),
        .mem_ready (mem_ready),
        .kind      (kind),
        .addr      (mem_addr),
        .reg_idx   (rf_raddr),
        .byte_sel  (byte_sel),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done)
    );

    mss_lane_fmt u_fmt (
        .clk      (clk),
        .rst      (rst),
        .we       (mem_we),
        .kind     (kind),
        .lane     (mem_addr[LANE_W-1:0]),
        .byte_sel (byte_sel),
        .rf_rdata (rf_rdata),
        .wdata    (mem_wdata),
        .be       (mem_be)
    );

    // R1: nothing is requested or signalled in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!mem_we && !done && !busy));
endmodule

// File: tb/tb_mss_store_seq.sv
module tb_mss_store_seq;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [1:0] mode;
    logic [4:0] src_reg;
    logic base_is_r0;
    logic [31:0] base_val;
    logic [15:0] disp;
    logic [31:0] index_val;
    logic [4:0] imm_count;
    logic [6:0] xfer_count;
    logic [4:0] rf_raddr;
    logic [31:0] rf_rdata;
    logic mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0] mem_be;
    logic mem_ready;
    logic busy;
    logic done;

    logic [31:0] regs [32];
    assign rf_rdata = regs[rf_raddr];

    logic [31:0] exp_a [128];
    logic [31:0] exp_d [128];
    logic [3:0]  exp_b [128];
    int exp_n;
    int checks = 0;
    int fails = 0;
    int unsigned seed_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    mss_store_seq dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic scramble_cmd();
        mode       = 2'($urandom);
        src_reg    = 5'($urandom);
        base_is_r0 = 1'($urandom);
        base_val   = $urandom;
        disp       = 16'($urandom);
        index_val  = $urandom;
        imm_count  = 5'($urandom);
        xfer_count = 7'($urandom);
    endtask

    task automatic build_expected(input logic [1:0] m, input logic [4:0] rs, input bit raz,
                                  input logic [31:0] rav, input logic [15:0] d, input logic [31:0] rb,
                                  input logic [4:0] nb, input logic [6:0] tbc);
        logic [31:0] base, ea;
        int n;
        base = raz ? 32'h0 : rav;
        exp_n = 0;
        if (m == 2'b00) begin
            ea = base + {{16{d[15]}}, d};
            for (int r = int'(rs); r < 32; r++) begin
                exp_a[exp_n] = ea + 32'(4 * (r - int'(rs)));
                exp_d[exp_n] = regs[r];
                exp_b[exp_n] = 4'hF;
                exp_n++;
            end
        end else begin
            ea = (m == 2'b01) ? base : base + rb;
            n  = (m == 2'b01) ? ((nb == 0) ? 32 : int'(nb)) : int'(tbc);
            for (int i = 0; i < n; i++) begin
                logic [31:0] a, w;
                logic [7:0] b;
                int lane;
                w = regs[(int'(rs) + i / 4) % 32];
                b = 8'(w >> (8 * (3 - (i % 4))));
                a = ea + 32'(i);
                lane = int'(a[1:0]);
                exp_a[exp_n] = a;
                exp_d[exp_n] = 32'(b) << (8 * (3 - lane));
                exp_b[exp_n] = 4'b1000 >> lane;
                exp_n++;
            end
        end
    endtask

    task automatic run_op(input logic [1:0] m, input logic [4:0] rs, input bit raz,
                          input logic [31:0] rav, input logic [15:0] d, input logic [31:0] rb,
                          input logic [4:0] nb, input logic [6:0] tbc,
                          input int rdy_pct, input bit poke);
        int idx, cyc;
        bit finished, stalled, rdy;
        string atag, dtag;
        for (int r = 0; r < 32; r++) regs[r] = $urandom;
        build_expected(m, rs, raz, rav, d, rb, nb, tbc);
        atag = (m == 2'b00) ? "R2 addr" : (m == 2'b01) ? "R3 addr" : "R4 addr";
        dtag = (m == 2'b00) ? "R2 data" : "R6 data";
        if (raz) atag = "R10 addr";
        @(negedge clk);
        mode = m; src_reg = rs; base_is_r0 = raz; base_val = rav; disp = d;
        index_val = rb; imm_count = nb; xfer_count = tbc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scramble_cmd();
        idx = 0; cyc = 0; finished = 0; stalled = 0;
        while (!finished && cyc < 2000) begin
            if (done) begin
                chk(idx == exp_n, "R8 writes before done", 32'(idx), 32'(exp_n));
                chk(busy, "R8 busy in done cycle", 32'(busy), 32'd1);
                if (exp_n == 0) chk(cyc == 0, "R8 zero count done timing", 32'(cyc), 32'd0);
                finished = 1;
            end else begin
                chk(busy, "R8 busy during run", 32'(busy), 32'd1);
                if (mem_we) begin
                    if (idx >= exp_n) begin
                        chk(0, "R2 extra write", 32'(idx), 32'(exp_n));
                    end else begin
                        chk(mem_addr == exp_a[idx], stalled ? "R7 addr hold" : atag, mem_addr, exp_a[idx]);
                        chk(mem_wdata == exp_d[idx], stalled ? "R7 data hold" : dtag, mem_wdata, exp_d[idx]);
                        chk(mem_be == exp_b[idx], (m == 2'b00) ? "R2 strobes" : "R5 strobes",
                            32'(mem_be), 32'(exp_b[idx]));
                    end
                end else begin
                    chk(0, "R8 no request while running", 32'(mem_we), 32'd1);
                end
                rdy = ($urandom % 100) < rdy_pct;
                mem_ready = rdy;
                stalled = mem_we && !rdy;
                if (mem_we && rdy) idx++;
                start = (poke && cyc == 2);
                if (poke && cyc == 2) scramble_cmd();
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        if (!finished) chk(0, "R8 done never seen", 32'(cyc), 32'd0);
        chk(!done && !busy && !mem_we, poke ? "R9 idle after ignored start" : "R8 single done pulse",
            {29'd0, done, busy, mem_we}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "watchdog expired", 32'd0, 32'd1);
        report();
    end

    initial begin
        seed_val = $urandom(32'd4242);
        rst = 1'b1; start = 1'b0; mem_ready = 1'b0;
        scramble_cmd();
        for (int r = 0; r < 32; r++) regs[r] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && !mem_we, "R1 reset state", {29'd0, busy, done, mem_we}, 32'd0);

        // directed corner cases
        run_op(2'b00, 5'd0,  0, 32'h0000_1000, 16'h0010, 32'h0, 5'd0, 7'd0, 100, 0); // R2 full run
        run_op(2'b00, 5'd31, 0, 32'h0000_2000, 16'hFFF0, 32'h0, 5'd0, 7'd0, 40, 0);  // R2 single word, negative disp
        run_op(2'b01, 5'd4,  0, 32'h0000_3001, 16'h0, 32'h0, 5'd0, 7'd0, 70, 0);     // R3 zero means 32
        run_op(2'b01, 5'd31, 0, 32'h0000_4002, 16'h0, 32'h0, 5'd5, 7'd0, 100, 0);    // R6 wrap, partial
        run_op(2'b10, 5'd30, 0, 32'h0000_5000, 16'h0, 32'h3, 5'd0, 7'd13, 30, 0);    // R4 R6 wrap
        run_op(2'b10, 5'd7,  0, 32'h0000_6000, 16'h0, 32'h0, 5'd0, 7'd0, 100, 0);    // R8 zero count
        run_op(2'b11, 5'd3,  0, 32'h0000_7000, 16'h0, 32'h1, 5'd0, 7'd127, 80, 1);   // R9 stray start
        run_op(2'b00, 5'd20, 1, 32'hDEAD_BEEF, 16'h0100, 32'h0, 5'd0, 7'd0, 60, 0);  // R10 literal zero base
        run_op(2'b10, 5'd9,  1, 32'hFFFF_0000, 16'h0, 32'h21, 5'd0, 7'd6, 50, 0);    // R10 indexed

        // constrained random
        for (int k = 0; k < 40; k++) begin
            run_op(2'($urandom), 5'($urandom), 1'(($urandom % 4) == 0), $urandom,
                   16'($urandom), $urandom, 5'($urandom), 7'($urandom % 48),
                   30 + int'($urandom % 71), (k % 10) == 5);
        end
        report();
    end
endmodule